// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core: two external request lines, two timer overflow events and one serial port. Each source can be masked individually and globally, and each is placed in a high or a low priority level. When a source wins, the controller raises a one-cycle acknowledge to the core together with the handler's vector address and the level it runs at.

The controller also remembers which levels currently have a handler running. A high-level request may interrupt a low-level handler; nothing interrupts a high-level handler, and a low-level request waits until no handler is running at all. A return pulse from the core closes the innermost open level. The external lines are active low and each can be switched between level sensing and falling-edge sensing; edge events and timer overflows are latched in flags that the acknowledge clears. The serial request is the OR of the receive and transmit flags, which live outside the block and are never cleared by it.

Top module: `dual_level_irq_ctrl`

## Requirements
- R1: Source indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial; every bit-per-source input uses bit i for index i, and the vector given with an acknowledge is 0x0003 + 8*i (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R2: A request is taken only when `glb_en` is 1 and the source's bit in `src_en` is 1; otherwise no acknowledge occurs and a latched flag stays set.
- R3: Among simultaneous requests of one level, the lowest source index wins.
- R4: Among simultaneous requests, one whose `src_hi` bit is 1 wins over any whose bit is 0.
- R5: A high request preempts a running low handler; while a high handler runs (`in_service[1]`=1) no request is acknowledged.
- R6: A low request is acknowledged only when `in_service` is 0; it does not preempt a running low handler and is taken once that handler returns.
- R7: With the `ext_edge_mode` bit at 1, a falling edge on the `ext_n` line sets `ext_flag`, which requests and is cleared by its acknowledge; holding the line low does not request again. With the bit at 0, the line requests while it is low and `ext_flag` stays 0.
- R8: A one-cycle `tmr_ovf` pulse sets `tmr_flag`, which holds until that timer's acknowledge clears it.
- R9: The serial request is `ser_rx_flag` OR `ser_tx_flag`; taking it leaves the request standing, so it is taken again after the handler returns.
- R10: A `reti` pulse clears `in_service[1]` if set, else `in_service[0]`.
- R11: `irq_ack` is registered: it is high for the cycle after the request is visible at the arbiter, with `irq_vector` and `irq_high` valid in that cycle, and the taken level's `in_service` bit set in that same cycle; a high acknowledge is never followed directly by another.
- R12: After reset `irq_ack`, `in_service`, `ext_flag` and `tmr_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | External request lines, active low |
| ext_edge_mode | input | 2 | Per external line: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer overflow event pulses |
| ser_rx_flag | input | 1 | Serial receive-complete flag |
| ser_tx_flag | input | 1 | Serial transmit-complete flag |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enables |
| src_hi | input | 5 | Per-source level, 1 = high |
| reti | input | 1 | Return-from-handler pulse |
| irq_ack | output | 1 | Take-interrupt pulse to the core |
| irq_vector | output | 16 | Handler address, valid with irq_ack |
| irq_high | output | 1 | Level of the taken source, valid with irq_ack |
| ext_flag | output | 2 | Latched falling-edge flags |
| tmr_flag | output | 2 | Latched timer overflow flags |
| in_service | output | 2 | Open levels: bit 1 high, bit 0 low |

## Verification
Requests that come straight from an input (a low external level in level mode, a serial flag) produce the acknowledge one clock after they are driven, while a falling edge or a timer pulse first lands in its flag and acknowledges one clock later, two in all. A return pulse changes `in_service` at the next edge, but the arbiter decides on the state before that edge, so a waiting request is acknowledged one clock after the return is visible. The bench drives on the falling clock edge and samples on a later falling edge after exactly these counts of rising edges, and for waiting or masked requests it samples every cycle of the window to see that no acknowledge appears.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC   = 5;
    localparam int NEXT   = 2;
    localparam int NTMR   = 2;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] VEC_BASE = 16'h0003;
    localparam logic [ADDR_W-1:0] VEC_STEP = 16'h0008;

    // Polling order: index 0 is polled first.
    localparam logic [IDX_W-1:0] SRC_EXT0 = 3'd0;
    localparam logic [IDX_W-1:0] SRC_TMR0 = 3'd1;
    localparam logic [IDX_W-1:0] SRC_EXT1 = 3'd2;
    localparam logic [IDX_W-1:0] SRC_TMR1 = 3'd3;
    localparam logic [IDX_W-1:0] SRC_SER  = 3'd4;

    typedef struct packed {
        logic              ack;
        logic              high;
        logic [ADDR_W-1:0] vector;
    } take_out_t;

    function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] wide;
        wide = {{(ADDR_W-IDX_W){1'b0}}, idx};
        return VEC_BASE + wide * VEC_STEP;
    endfunction

endpackage

// File: rtl/irq_ext_line.sv
module irq_ext_line (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req,
    output logic flag
);
    typedef struct packed {
        logic line_prev;
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.line_prev = line_n;
        if (!edge_mode) begin
            st_d.flag = 1'b0;
        end else if (st_q.line_prev && !line_n) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{line_prev: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign req  = edge_mode ? st_q.flag : !line_n;

    // R7: a sampled falling edge in edge mode leaves the flag set
    assert_edge_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $fell(line_n)) |=> flag);

    // R7: level mode never holds a flag
    assert_level_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (!flag || $past(edge_mode) == 1'b0 && edge_mode));

endmodule

// File: rtl/irq_evt_flag.sv
module irq_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

    // R8: an overflow pulse is never lost
    assert_set_latches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R8: without a clear the flag holds
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [NSRC-1:0]  req_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic [1:0]       in_service,
    output logic             take,
    output logic             take_high,
    output logic [IDX_W-1:0] take_idx
);
    logic [NSRC-1:0]  hi_req, lo_req;
    logic             hi_any, lo_any;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    assign hi_req = req_en & src_hi;
    assign lo_req = req_en & ~src_hi;

    // Scan from the last source back so the lowest index is kept.
    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_req[i]) begin
                hi_any = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (lo_req[i]) begin
                lo_any = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        take      = 1'b0;
        take_high = 1'b0;
        take_idx  = '0;
        if (!in_service[1]) begin
            if (hi_any) begin
                take      = 1'b1;
                take_high = 1'b1;
                take_idx  = hi_idx;
            end else if (lo_any && !in_service[0]) begin
                take      = 1'b1;
                take_idx  = lo_idx;
            end
        end
    end

    // R4: a taken low source means no enabled high request existed
    assert_high_first_R4: assert final (!(take && !take_high) || hi_req == '0);

endmodule

// File: rtl/irq_nest.sv
module irq_nest (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_high,
    input  logic       reti,
    output logic [1:0] in_service
);
    logic [1:0] ins_d, ins_q;

    always_comb begin
        ins_d = ins_q;
        if (reti) begin
            if (ins_q[1]) begin
                ins_d[1] = 1'b0;
            end else begin
                ins_d[0] = 1'b0;
            end
        end
        if (take) begin
            ins_d[take_high ? 1 : 0] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ins_q <= '0;
        end else begin
            ins_q <= ins_d;
        end
    end

    assign in_service = ins_q;

    // R10: a return with the high level open and no new take drops it
    assert_reti_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_service[1] && !take) |=> !in_service[1]);

    // R10: a return while only low is open closes low
    assert_reti_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && in_service == 2'b01 && !take) |=> in_service == 2'b00);

endmodule

// File: rtl/dual_level_irq_ctrl.sv
module dual_level_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NEXT-1:0]   ext_n,
    input  logic [NEXT-1:0]   ext_edge_mode,
    input  logic [NTMR-1:0]   tmr_ovf,
    input  logic              ser_rx_flag,
    input  logic              ser_tx_flag,
    input  logic              glb_en,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   src_hi,
    input  logic              reti,
    output logic              irq_ack,
    output logic [ADDR_W-1:0] irq_vector,
    output logic              irq_high,
    output logic [NEXT-1:0]   ext_flag,
    output logic [NTMR-1:0]   tmr_flag,
    output logic [1:0]        in_service
);
    localparam logic [IDX_W-1:0] EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};
    localparam logic [IDX_W-1:0] TMR_IDX [NTMR] = '{SRC_TMR0, SRC_TMR1};

    logic [NEXT-1:0]  ext_req;
    logic [NSRC-1:0]  raw_req, req_en;
    logic             take, take_high;
    logic [IDX_W-1:0] take_idx;

    take_out_t out_d, out_q;

    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        irq_ext_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .line_n    (ext_n[e]),
            .edge_mode (ext_edge_mode[e]),
            .clr       (take && take_idx == EXT_IDX[e]),
            .req       (ext_req[e]),
            .flag      (ext_flag[e])
        );
        assign raw_req[EXT_IDX[e]] = ext_req[e];
    end

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        irq_evt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (tmr_ovf[t]),
            .clr   (take && take_idx == TMR_IDX[t]),
            .flag  (tmr_flag[t])
        );
        assign raw_req[TMR_IDX[t]] = tmr_flag[t];
    end

    assign raw_req[SRC_SER] = ser_rx_flag | ser_tx_flag;
    assign req_en           = raw_req & src_en & {NSRC{glb_en}};

    irq_pick u_pick (
        .req_en     (req_en),
        .src_hi     (src_hi),
        .in_service (in_service),
        .take       (take),
        .take_high  (take_high),
        .take_idx   (take_idx)
    );

    irq_nest u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_high  (take_high),
        .reti       (reti),
        .in_service (in_service)
    );

    always_comb begin
        out_d     = out_q;
        out_d.ack = take;
        if (take) begin
            out_d.high   = take_high;
            out_d.vector = vec_of(take_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{ack: 1'b0, high: 1'b0, vector: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_ack    = out_q.ack;
    assign irq_high   = out_q.high;
    assign irq_vector = out_q.vector;

    // R11: the taken level is open in the acknowledge cycle
    assert_ack_opens_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> in_service[irq_high ? 1 : 0]);

    // R11: a high acknowledge is isolated
    assert_high_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_high) |=> !irq_ack);

    // R5: nothing is taken while a high handler was open
    assert_no_preempt_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !$past(in_service[1]));

    // R6: a low take needs an idle nest
    assert_low_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_high) |-> $past(in_service) == 2'b00);

    // R1: vectors lie on the 8-byte grid starting at 3
    assert_vec_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (irq_vector[2:0] == 3'b011 && irq_vector <= 16'h0023));

endmodule

// File: tb/dual_level_irq_ctrl_tb.sv
module dual_level_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge_mode = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx_flag = 1'b0;
    logic        ser_tx_flag = 1'b0;
    logic        glb_en = 1'b0;
    logic [4:0]  src_en = 5'b0;
    logic [4:0]  src_hi = 5'b0;
    logic        reti = 1'b0;
    logic        irq_ack;
    logic [15:0] irq_vector;
    logic        irq_high;
    logic [1:0]  ext_flag;
    logic [1:0]  tmr_flag;
    logic [1:0]  in_service;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dual_level_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge_mode(ext_edge_mode),
        .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
        .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi), .reti(reti),
        .irq_ack(irq_ack), .irq_vector(irq_vector), .irq_high(irq_high),
        .ext_flag(ext_flag), .tmr_flag(tmr_flag), .in_service(in_service)
    );

    // drv bits: 0 = ext 0 low, 1 = ext 1 low, 2 = serial rx high
    typedef struct packed {
        logic        gen;
        logic [4:0]  en;
        logic [4:0]  hi;
        logic [2:0]  drv;
        logic        ack;
        logic [15:0] vec;
        logic        lvl;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'b11111, 5'b00000, 3'b001, 1'b1, 16'h0003, 1'b0}, // R1
        '{1'b1, 5'b11111, 5'b00000, 3'b010, 1'b1, 16'h0013, 1'b0}, // R1
        '{1'b1, 5'b11111, 5'b00000, 3'b100, 1'b1, 16'h0023, 1'b0}, // R1
        '{1'b1, 5'b11111, 5'b00000, 3'b111, 1'b1, 16'h0003, 1'b0}, // R3
        '{1'b1, 5'b11111, 5'b10000, 3'b111, 1'b1, 16'h0023, 1'b1}, // R4
        '{1'b1, 5'b11111, 5'b00100, 3'b011, 1'b1, 16'h0013, 1'b1}, // R4
        '{1'b1, 5'b11111, 5'b10100, 3'b111, 1'b1, 16'h0013, 1'b1}, // R3
        '{1'b0, 5'b11111, 5'b00000, 3'b111, 1'b0, 16'h0000, 1'b0}, // R2
        '{1'b1, 5'b00000, 5'b00000, 3'b111, 1'b0, 16'h0000, 1'b0}, // R2
        '{1'b1, 5'b10100, 5'b00000, 3'b111, 1'b1, 16'h0013, 1'b0}, // R2
        '{1'b1, 5'b10000, 5'b00000, 3'b101, 1'b1, 16'h0023, 1'b0}  // R2
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_reti();
        reti = 1'b1;
        tick(1);
        reti = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R12 reset state
        chk("R12 ack", irq_ack, 0);
        chk("R12 in_service", in_service, 0);
        chk("R12 ext_flag", ext_flag, 0);
        chk("R12 tmr_flag", tmr_flag, 0);

        for (int k = 0; k < NV; k++) begin
            glb_en      = TBL[k].gen;
            src_en      = TBL[k].en;
            src_hi      = TBL[k].hi;
            ext_n[0]    = !TBL[k].drv[0];
            ext_n[1]    = !TBL[k].drv[1];
            ser_rx_flag = TBL[k].drv[2];
            tick(1);
            chk("R11 table ack", irq_ack, TBL[k].ack);
            if (TBL[k].ack) begin
                chk("R1 table vector", irq_vector, TBL[k].vec);
                chk("R4 table level", irq_high, TBL[k].lvl);
                chk("R11 table in_service", in_service, TBL[k].lvl ? 2'b10 : 2'b01);
            end
            ext_n = 2'b11;
            ser_rx_flag = 1'b0;
            if (TBL[k].ack) begin
                pulse_reti();
            end else begin
                tick(1);
                chk("R2 masked no ack", irq_ack, 0);
            end
            chk("R10 table idle", in_service, 0);
        end

        // Nesting: R5 R6 R10
        glb_en = 1'b1; src_en = 5'b11111; src_hi = 5'b10000;
        ext_n[1] = 1'b0;
        tick(1);
        chk("R6 low taken", irq_vector, 16'h0013);
        chk("R6 low in_service", in_service, 2'b01);
        ext_n[0] = 1'b0;
        tick(1);
        chk("R6 no low preempt", irq_ack, 0);
        tick(1);
        chk("R6 no low preempt 2", irq_ack, 0);
        ser_rx_flag = 1'b1;
        tick(1);
        chk("R5 high preempts ack", irq_ack, 1);
        chk("R5 high preempts vector", irq_vector, 16'h0023);
        chk("R5 high level", irq_high, 1);
        chk("R5 both open", in_service, 2'b11);
        src_hi = 5'b10001;
        tick(1);
        chk("R5 high not preempted", irq_ack, 0);
        tick(1);
        chk("R5 high not preempted 2", irq_ack, 0);
        ser_rx_flag = 1'b0; ext_n[0] = 1'b1; src_hi = 5'b10000;
        pulse_reti();
        chk("R10 high closed", in_service, 2'b01);
        chk("R10 no ack yet", irq_ack, 0);
        tick(1);
        chk("R6 still blocked", irq_ack, 0);
        pulse_reti();
        chk("R10 low closed", in_service, 2'b00);
        tick(1);
        chk("R6 taken after return", irq_vector, 16'h0013);
        chk("R7 level re-requests", irq_ack, 1);
        ext_n[1] = 1'b1;
        pulse_reti();

        // Edge mode: R7
        src_hi = 5'b00000; ext_edge_mode = 2'b01;
        tick(1);
        ext_n[0] = 1'b0;
        tick(1);
        chk("R7 edge flag set", ext_flag[0], 1);
        chk("R7 no ack yet", irq_ack, 0);
        tick(1);
        chk("R7 edge ack", irq_ack, 1);
        chk("R7 edge vector", irq_vector, 16'h0003);
        chk("R7 flag cleared", ext_flag[0], 0);
        pulse_reti();
        tick(1);
        chk("R7 held low no retrigger", irq_ack, 0);
        tick(1);
        chk("R7 held low no retrigger 2", irq_ack, 0);
        ext_n[0] = 1'b1; ext_edge_mode = 2'b00;
        tick(1);

        // Timer: R8 R2
        glb_en = 1'b0;
        tmr_ovf[1] = 1'b1;
        tick(1);
        tmr_ovf[1] = 1'b0;
        chk("R8 flag set", tmr_flag[1], 1);
        tick(2);
        chk("R2 disabled no ack", irq_ack, 0);
        chk("R8 flag held", tmr_flag[1], 1);
        glb_en = 1'b1;
        tick(1);
        chk("R8 timer ack", irq_ack, 1);
        chk("R1 timer vector", irq_vector, 16'h001B);
        chk("R8 flag cleared", tmr_flag[1], 0);
        pulse_reti();

        // Serial: R9
        ser_tx_flag = 1'b1;
        tick(1);
        chk("R9 tx ack", irq_ack, 1);
        chk("R9 vector", irq_vector, 16'h0023);
        tick(2);
        chk("R9 no repeat in service", irq_ack, 0);
        pulse_reti();
        chk("R9 none in return cycle", irq_ack, 0);
        tick(1);
        chk("R9 retaken", irq_ack, 1);
        ser_tx_flag = 1'b0;
        pulse_reti();
        chk("R10 final idle", in_service, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule